// File: doc/BRIEF.md
# Peak-and-Hold Solenoid Current Controller

This block regulates the current in a solenoid coil that is switched through an external transistor. Raising the enable input starts an activation. The block first waits a start-up delay with the gate off. It then runs a fixed-rate PWM clock that is derived from the system clock. Each PWM period begins with the gate on. The gate turns off at the clock edge after the digitized coil current is seen above the active reference, and it stays off until the next period. A minimum on-time is always given. If the current never reaches the reference, the gate stays on through the period boundary, so the duty can reach 100%.

The reference starts at a high pull-in (peak) level, which makes sure the armature moves. After a programmable number of PWM periods it drops to a lower holding level, which cuts dissipation. An undervoltage flag and a digitized junction temperature can each block switching. The temperature path has hysteresis. A status pull-down output is active while no fault is present. Dropping enable turns the gate off in the same cycle, and the next rising edge of enable starts the whole sequence again.

Top module: `solenoid_pwm_ctrl`

## Requirements
- R1: After reset, gate_o is 0, state_o is 0 (idle) and status_pd_o is 1.
- R2: When en_i is sampled high in the idle state, state_o becomes 1 (start-up). It stays 1, with gate_o low, for STARTUP_PERIODS*PERIOD_CYC clock cycles. Phase 0 of the first regulated period follows.
- R3: In the regulated states, the gate is high at phase 0 of every PWM period unless a fault was sampled at that period's first edge. The phase counts system clocks from 0 to PERIOD_CYC-1.
- R4: From phase MIN_ON upward, isense_i sampled strictly above the active reference drives gate_o low from the next clock. It stays low to the end of the period. A sample equal to the reference does not turn the gate off.
- R5: Each on-cycle keeps the gate high for at least MIN_ON = ceil(PERIOD_CYC*0.075) cycles, whatever isense_i is.
- R6: If isense_i never exceeds the reference, gate_o stays high for the whole period and across the next period boundary (100% duty).
- R7: state_o is 2 (peak, reference PEAK_REF) for KEEP_PERIODS periods after start-up. It then becomes 3 (hold, reference HOLD_REF, by default PEAK_REF/6) and stays there while en_i is high.
- R8: When en_i is low, gate_o is low in the same cycle, and state_o returns to 0 at the next clock. A new enable restarts the start-up delay and the peak time from the beginning.
- R9: A high uvlo_i sampled at a clock edge makes gate_o and status_pd_o low after that edge.
- R10: Thermal shutdown sets when temp_i >= TSD_ON and clears only when temp_i < TSD_OFF. Between the two thresholds it keeps its last value. While it is set, the gate is blocked and status_pd_o is 0.
- R11: If a fault is seen during a period, the gate stays low until the first period start at which no fault is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Activation request |
| isense_i | input | CUR_W | Digitized coil current sample |
| uvlo_i | input | 1 | Undervoltage flag |
| temp_i | input | TEMP_W | Digitized junction temperature |
| gate_o | output | 1 | Gate drive for the external switch |
| state_o | output | 2 | 0 idle, 1 start-up, 2 peak, 3 hold |
| status_pd_o | output | 1 | Status pull-down active (no fault) |

## Verification
The hardest situation to reach is a fault that arrives in the middle of a hold period and clears before that period ends. The gate has to stay off until the next boundary, and the same must hold when the fault covers only the boundary edge itself. The bench reaches this by counting cycles from the enable edge, so that it knows the phase of every sample. It then raises the undervoltage flag at chosen phases. It also walks the temperature across both thresholds, from above and from below. In every regulated period it sweeps the cycle at which the current first exceeds the reference, from before the minimum on-time to beyond the period length.

// File: rtl/sol_pkg.sv
package sol_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_PEAK  = 2'd2,
    ST_HOLD  = 2'd3
  } sol_state_e;
endpackage

// File: rtl/sol_timebase.sv
module sol_timebase #(
  parameter int PERIOD_CYC = 2500,
  localparam int PHASE_W = $clog2(PERIOD_CYC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic [PHASE_W-1:0] phase_d_o,
  output logic               wrap_o
);
  logic [PHASE_W-1:0] phase_q;

  assign wrap_o = (phase_q == PHASE_W'(PERIOD_CYC - 1));

  always_comb begin
    if (!run_i)      phase_d_o = '0;
    else if (wrap_o) phase_d_o = '0;
    else             phase_d_o = phase_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_d_o;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/sol_sequencer.sv
module sol_sequencer
  import sol_pkg::*;
#(
  parameter int STARTUP_PERIODS = 1,
  parameter int KEEP_PERIODS    = 2000,
  localparam int CNT_MAX = (STARTUP_PERIODS > KEEP_PERIODS) ? STARTUP_PERIODS : KEEP_PERIODS,
  localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       wrap_i,
  output sol_state_e state_o,
  output sol_state_e state_d_o
);
  sol_state_e       state_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d_o = state_q;
    cnt_d     = cnt_q;
    if (!en_i) begin
      state_d_o = ST_IDLE;
      cnt_d     = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d_o = ST_START;
          cnt_d     = '0;
        end
        ST_START: if (wrap_i) begin
          if (cnt_q == CNT_W'(STARTUP_PERIODS - 1)) begin
            state_d_o = ST_PEAK;
            cnt_d     = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_PEAK: if (wrap_i) begin
          if (cnt_q == CNT_W'(KEEP_PERIODS - 1)) begin
            state_d_o = ST_HOLD;
            cnt_d     = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d_o;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/sol_fault_gate.sv
module sol_fault_gate #(
  parameter int TEMP_W  = 8,
  parameter int TSD_ON  = 160,
  parameter int TSD_OFF = 140
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              uvlo_i,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              fault_d_o,
  output logic              fault_q_o
);
  logic tsd_q, tsd_d, uv_q;

  // hysteresis: hold last value between thresholds
  always_comb begin
    tsd_d = tsd_q;
    if (temp_i >= TEMP_W'(TSD_ON))      tsd_d = 1'b1;
    else if (temp_i < TEMP_W'(TSD_OFF)) tsd_d = 1'b0;
  end

  assign fault_d_o = uvlo_i | tsd_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tsd_q <= 1'b0;
      uv_q  <= 1'b0;
    end else begin
      tsd_q <= tsd_d;
      uv_q  <= uvlo_i;
    end
  end

  assign fault_q_o = uv_q | tsd_q;
endmodule

// File: rtl/sol_gate_ctrl.sv
module sol_gate_ctrl #(
  parameter int CUR_W   = 12,
  parameter int PHASE_W = 12,
  parameter int MIN_ON  = 188
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               block_i,
  input  logic               start_i,
  input  logic [PHASE_W-1:0] phase_d_i,
  input  logic [CUR_W-1:0]   isense_i,
  input  logic [CUR_W-1:0]   ref_i,
  output logic               gate_o
);
  logic gate_q, gate_d;

  always_comb begin
    gate_d = gate_q;
    if (!run_i || block_i)
      gate_d = 1'b0;
    else if (start_i)
      gate_d = 1'b1;
    else if (phase_d_i >= PHASE_W'(MIN_ON) && isense_i > ref_i)
      gate_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= gate_d;
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/solenoid_pwm_ctrl.sv
module solenoid_pwm_ctrl
  import sol_pkg::*;
#(
  parameter int PERIOD_CYC      = 2500,
  parameter int STARTUP_PERIODS = 1,
  parameter int KEEP_PERIODS    = 2000,
  parameter int CUR_W           = 12,
  parameter int PEAK_REF        = 300,
  parameter int HOLD_REF        = PEAK_REF / 6,
  parameter int TEMP_W          = 8,
  parameter int TSD_ON          = 160,
  parameter int TSD_OFF         = 140,
  localparam int PHASE_W    = $clog2(PERIOD_CYC),
  localparam int MIN_ON_CYC = (PERIOD_CYC * 75 + 999) / 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CUR_W-1:0]  isense_i,
  input  logic              uvlo_i,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              gate_o,
  output logic [1:0]        state_o,
  output logic              status_pd_o
);
  sol_state_e         state_q, state_d;
  logic [PHASE_W-1:0] phase_q, phase_d;
  logic               wrap;
  logic               fault_d, fault_q;
  logic               gate_q;
  logic [CUR_W-1:0]   ref_lvl;

  sol_timebase #(.PERIOD_CYC(PERIOD_CYC)) u_tb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (en_i && state_q != ST_IDLE),
    .phase_o  (phase_q),
    .phase_d_o(phase_d),
    .wrap_o   (wrap)
  );

  sol_sequencer #(
    .STARTUP_PERIODS(STARTUP_PERIODS),
    .KEEP_PERIODS   (KEEP_PERIODS)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .wrap_i   (wrap),
    .state_o  (state_q),
    .state_d_o(state_d)
  );

  sol_fault_gate #(
    .TEMP_W (TEMP_W),
    .TSD_ON (TSD_ON),
    .TSD_OFF(TSD_OFF)
  ) u_flt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .uvlo_i   (uvlo_i),
    .temp_i   (temp_i),
    .fault_d_o(fault_d),
    .fault_q_o(fault_q)
  );

  assign ref_lvl = (state_q == ST_HOLD) ? CUR_W'(HOLD_REF) : CUR_W'(PEAK_REF);

  sol_gate_ctrl #(
    .CUR_W  (CUR_W),
    .PHASE_W(PHASE_W),
    .MIN_ON (MIN_ON_CYC)
  ) u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (en_i && (state_d == ST_PEAK || state_d == ST_HOLD)),
    .block_i  (fault_d),
    .start_i  (phase_d == '0),
    .phase_d_i(phase_d),
    .isense_i (isense_i),
    .ref_i    (ref_lvl),
    .gate_o   (gate_q)
  );

  // enable low kills the gate without waiting for a clock
  assign gate_o      = gate_q & en_i;
  assign state_o     = state_q;
  assign status_pd_o = ~fault_q;
endmodule

// File: rtl/sol_ctrl_chk.sv
module sol_ctrl_chk #(
  parameter int PHASE_W = 12,
  parameter int TEMP_W  = 8,
  parameter int MIN_ON  = 188,
  parameter int TSD_ON  = 160,
  parameter int TSD_OFF = 140
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic               uvlo_i,
  input logic [TEMP_W-1:0]  temp_i,
  input logic               gate_o,
  input logic [1:0]         state_o,
  input logic               status_pd_o,
  input logic [PHASE_W-1:0] phase_i
);
  AST_EN_LOW_GATE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !gate_o); // R8
  AST_START_GATE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1) |-> !gate_o); // R2
  AST_FAULT_BLOCKS_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_pd_o |-> !gate_o); // R9
  AST_PERIOD_START_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o[1] && phase_i == '0 && en_i && status_pd_o) |-> gate_o); // R3
  AST_MIN_ON_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(gate_o) && state_o[1] && phase_i != '0 && phase_i < PHASE_W'(MIN_ON)
     && en_i && status_pd_o) |-> gate_o); // R5
  AST_HOLD_AFTER_PEAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd3) |-> ($past(state_o) == 2'd2 || $past(state_o) == 2'd3)); // R7
  AST_TSD_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_i >= TEMP_W'(TSD_ON)) |=> !status_pd_o); // R10
  AST_TSD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_i < TEMP_W'(TSD_OFF) && !uvlo_i) |=> status_pd_o); // R10
endmodule

bind solenoid_pwm_ctrl sol_ctrl_chk #(
  .PHASE_W(PHASE_W),
  .TEMP_W (TEMP_W),
  .MIN_ON (MIN_ON_CYC),
  .TSD_ON (TSD_ON),
  .TSD_OFF(TSD_OFF)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .uvlo_i     (uvlo_i),
  .temp_i     (temp_i),
  .gate_o     (gate_o),
  .state_o    (state_o),
  .status_pd_o(status_pd_o),
  .phase_i    (phase_q)
);

// File: tb/solenoid_pwm_ctrl_test.sv
module solenoid_pwm_ctrl_test;
  localparam int P     = 40;
  localparam int S     = 1;
  localparam int K     = 3;
  localparam int CW    = 10;
  localparam int TW    = 8;
  localparam int PK    = 300;
  localparam int HD    = PK / 6;
  localparam int TON   = 160;
  localparam int TOFF  = 140;
  localparam int MINON = (P * 75 + 999) / 1000;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en = 1'b0;
  logic          uv = 1'b0;
  logic [TW-1:0] temp = 8'd25;
  logic [CW-1:0] isense = '0;
  logic          gate, status;
  logic [1:0]    st;

  always #10 clk = ~clk;

  solenoid_pwm_ctrl #(
    .PERIOD_CYC(P), .STARTUP_PERIODS(S), .KEEP_PERIODS(K), .CUR_W(CW),
    .PEAK_REF(PK), .TEMP_W(TW), .TSD_ON(TON), .TSD_OFF(TOFF)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .isense_i(isense),
    .uvlo_i(uv), .temp_i(temp), .gate_o(gate), .state_o(st), .status_pd_o(status)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit m_on = 1'b0;
  int k = 0;
  bit tsd = 1'b0;
  bit blocked = 1'b0;
  int salt = 1;
  int offs = 0;

  function automatic int trip(int m);
    return (m * salt + offs) % (P + 2);
  endfunction

  function automatic int st_of(int kk);
    if (kk < P * S) return 1;
    if (kk < P * (S + K)) return 2;
    return 3;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s k=%0d actual=%0d expected=%0d", req, k, act, exp);
    end
  endtask

  // one clock: drive isense, advance model, compare at negedge
  task automatic cyc();
    int kn, stc, stn, refc, t, ph, se, ge;
    bit fd;
    string rq;
    stc = m_on ? st_of(k) : 0;
    kn  = (m_on && en) ? k + 1 : 0;
    stn = st_of(kn);
    refc = (stc == 3) ? HD : PK;
    if (m_on && en && stc >= 2 && stn >= 2)
      isense = CW'(((kn % P) >= trip(kn / P - S)) ? refc + 1 : refc);
    else
      isense = '0;
    @(posedge clk);
    if (temp >= TW'(TON)) tsd = 1'b1;
    else if (temp < TW'(TOFF)) tsd = 1'b0;
    fd = uv | tsd;
    if (!en) m_on = 1'b0;
    else if (!m_on) begin m_on = 1'b1; k = 0; end
    else k++;
    se = m_on ? st_of(k) : 0;
    ge = 0;
    rq = "R8";
    if (m_on && se >= 2) begin
      ph = k % P;
      if (ph == 0) blocked = fd; else blocked = blocked | fd;
      t = trip(k / P - S);
      ge = (!blocked && ph < ((t > MINON) ? t : MINON)) ? 1 : 0;
      if (blocked)        rq = "R11";
      else if (ph == 0)   rq = "R3";
      else if (ph < MINON) rq = "R5";
      else if (t >= P)    rq = "R6";
      else                rq = "R4";
    end else if (m_on) rq = "R2";
    @(negedge clk);
    chk(rq, int'(gate), ge);
    chk((se >= 2) ? "R7" : "R2", int'(st), se);
    chk(tsd ? "R10" : "R9", int'(status), fd ? 0 : 1);
  endtask

  initial begin
    #(200000 * 20);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", int'(gate), 0);
    chk("R1", int'(st), 0);
    chk("R1", int'(status), 1);
    rst_ni = 1'b1;
    repeat (2) cyc();

    // R3 R4 R5 R6 R7: trip phase swept over every value
    en = 1'b1;
    repeat (P * (S + K + P + 2) + 1) cyc();

    // R8: drop enable with the gate high at phase 0
    chk("R3", int'(gate), 1);
    en = 1'b0;
    #1;
    chk("R8", int'(gate), 0);
    repeat (3) cyc();

    // R8: restart redoes start-up and peak, different sweep
    en = 1'b1;
    salt = 7;
    offs = 5;
    repeat (P * (S + K + 2) + 1) cyc();

    // R9 R11: undervoltage mid-period, cleared before the boundary
    salt = 0;
    offs = P + 1;
    repeat (5) cyc();
    uv = 1'b1;
    repeat (4) cyc();
    uv = 1'b0;
    repeat (P * 2 - 9) cyc();
    // R11: fault sampled only at a boundary edge
    repeat (P - 1) cyc();
    uv = 1'b1;
    cyc();
    uv = 1'b0;
    repeat (P * 2) cyc();

    // R10: hysteresis from both sides
    temp = 8'd170; repeat (3) cyc();
    temp = 8'd150; repeat (P) cyc();
    temp = 8'd140; repeat (3) cyc();
    temp = 8'd139; repeat (P * 2) cyc();
    temp = 8'd159; repeat (P) cyc();
    temp = 8'd160; repeat (2) cyc();
    temp = 8'd25;  repeat (P * 2) cyc();

    // R9: fault while idle still releases status
    en = 1'b0;
    repeat (2) cyc();
    uv = 1'b1;
    repeat (2) cyc();
    uv = 1'b0;
    repeat (2) cyc();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule